// File: doc/BRIEF.md
# Masked data breakpoint comparator

This block watches the data transfers on a processor's local bus and raises a trigger when the operand of a transfer equals a programmed value. Bits set in a mask register are left out of the comparison. It is one of the trigger sources of an on-chip debug unit. The unit that consumes the trigger handles address comparison, sequencing and halting the core.

Each bus cycle supplies a valid strobe, a direction flag, the access size, the two low address bits and the 32-bit data bus. The size and the address pick the byte lanes that carry the operand, with big-endian lane numbering. For a byte or word access, the selected lanes are shifted down to bit 0. They are then compared against the low bits of the value and mask registers. Because of this, a short operand matches at any position on the bus, aligned or not. The trigger is a registered pulse one clock after the matching bus cycle.

Software programs the block through a small write-only register port. One control register holds a master enable plus separate enables for reads and for writes. The other two registers hold the 32-bit value and the 32-bit mask.

Top module: `dbk_data_trig`

## Requirements
- R1: While rst_ni is low, hit_o is 0. Reset clears the control, value and mask registers, so after reset no bus cycle produces a hit until the block is enabled.
- R2: A mask bit of 0 includes the corresponding data bit in the comparison. A mask bit of 1 excludes it.
- R3: Longword access (bus_size_i = 00) compares all of bus_data_i[31:0] against the full value register, whatever bus_addr_i is.
- R4: Word access (bus_size_i = 10) compares bus_data_i[31:16] when bus_addr_i[1] is 0 and bus_data_i[15:0] when it is 1. bus_addr_i[0] has no effect.
- R5: Byte access (bus_size_i = 01) at bus_addr_i = 0, 1, 2, 3 compares bus_data_i[31:24], [23:16], [15:8], [7:0] respectively.
- R6: For a word or byte access, the selected lanes are compared against value[15:0] or value[7:0], under mask[15:0] or mask[7:0]. Upper register bits and unselected bus lanes have no effect.
- R7: A hit requires bus_valid_i = 1, the master enable set, and the enable for the cycle's direction set. The control register is at cfg_addr_i = 0: bit 0 is the master enable, bit 1 enables reads (bus_read_i = 1) and bit 2 enables writes (bus_read_i = 0).
- R8: hit_o is 1 for exactly the clock after each matching bus cycle. Back-to-back matches give back-to-back pulses, and a non-matching or idle cycle gives 0.
- R9: A register write (cfg_we_i = 1; value at cfg_addr_i = 1, mask at cfg_addr_i = 2) takes effect for bus cycles presented after the write cycle. A bus cycle in the same clock as the write uses the old contents. Writes to cfg_addr_i = 3 are ignored.
- R10: With an all-ones mask and the direction enabled, every valid access of a legal size hits.
- R11: Size code 11 is reserved and never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 control, 1 value, 2 mask |
| cfg_wdata_i | input | 32 | Register write data |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_read_i | input | 1 | 1 for a read, 0 for a write |
| bus_size_i | input | 2 | 00 longword, 01 byte, 10 word, 11 reserved |
| bus_addr_i | input | 2 | Low address bits of the transfer |
| bus_data_i | input | 32 | Data bus |
| hit_o | output | 1 | Registered breakpoint trigger pulse |

## Verification
The bench places a byte operand in each of the four lanes and a word operand in both halves, including at odd addresses. A design with the lane order reversed, or one that decodes A[0] for words, would miss these matches or report false ones.

It loads value registers whose upper bits differ from the bus, and drives bus lanes that the access does not select. A design that forgets to right-justify or to narrow the compare width would then fail to hit.

It writes a register in the same clock as a bus cycle, which exposes a design that compares against the freshly written value. It also checks direction enables, the reserved size code and an all-ones mask, which catch a design that ignores the direction of the cycle or the size code.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    CFG_CTRL  = 2'b00,
    CFG_VALUE = 2'b01,
    CFG_MASK  = 2'b10,
    CFG_NONE  = 2'b11
  } cfg_sel_e;

  typedef struct packed {
    logic wr_en;
    logic rd_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dbk_regs.sv
module dbk_regs
  import dbk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] value_o,
  output logic [DATA_W-1:0] mask_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] value_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      value_q <= '0;
      mask_q  <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(addr_i))
        CFG_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        CFG_VALUE: value_q <= wdata_i;
        CFG_MASK:  mask_q  <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign value_o = value_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/dbk_lane_sel.sv
module dbk_lane_sel
  import dbk_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NUM_B = DATA_W / 8,
  localparam int NUM_H = DATA_W / 16,
  localparam int AW    = $clog2(NUM_B)
) (
  input  logic [1:0]        size_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] oper_o,
  output logic [DATA_W-1:0] wmask_o,
  output logic              size_ok_o
);
  logic [7:0]  byte_lane [NUM_B];
  logic [15:0] half_lane [NUM_H];

  // Big-endian numbering: lowest address maps to the most significant lane
  for (genvar g = 0; g < NUM_B; g++) begin : g_byte
    assign byte_lane[g] = data_i[8*(NUM_B-1-g) +: 8];
  end
  for (genvar h = 0; h < NUM_H; h++) begin : g_half
    assign half_lane[h] = data_i[16*(NUM_H-1-h) +: 16];
  end

  always_comb begin
    oper_o    = '0;
    wmask_o   = '0;
    size_ok_o = 1'b1;
    unique case (size_e'(size_i))
      SZ_LONG: begin
        oper_o  = data_i;
        wmask_o = '1;
      end
      SZ_WORD: begin
        oper_o[15:0]  = half_lane[addr_i[AW-1:1]];
        wmask_o[15:0] = '1;
      end
      SZ_BYTE: begin
        oper_o[7:0]  = byte_lane[addr_i];
        wmask_o[7:0] = '1;
      end
      default: size_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbk_cmp.sv
module dbk_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] oper_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] wmask_i,
  output logic              match_o
);
  logic [DATA_W-1:0] diff;

  assign diff    = (oper_i ^ value_i) & wmask_i & ~mask_i;
  assign match_o = ~|diff;
endmodule

// File: rtl/dbk_data_trig.sv
module dbk_data_trig
  import dbk_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DATA_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              bus_valid_i,
  input  logic              bus_read_i,
  input  logic [1:0]        bus_size_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              hit_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] value_q, mask_q;
  logic [DATA_W-1:0] oper, wmask;
  logic              size_ok, match, dir_ok, fire, hit_q;

  dbk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .ctrl_o  (ctrl_q),
    .value_o (value_q),
    .mask_o  (mask_q)
  );

  dbk_lane_sel #(.DATA_W(DATA_W)) u_lane (
    .size_i    (bus_size_i),
    .addr_i    (bus_addr_i),
    .data_i    (bus_data_i),
    .oper_o    (oper),
    .wmask_o   (wmask),
    .size_ok_o (size_ok)
  );

  dbk_cmp #(.DATA_W(DATA_W)) u_cmp (
    .oper_i  (oper),
    .value_i (value_q),
    .mask_i  (mask_q),
    .wmask_i (wmask),
    .match_o (match)
  );

  assign dir_ok = bus_read_i ? ctrl_q.rd_en : ctrl_q.wr_en;
  assign fire   = bus_valid_i & ctrl_q.en & dir_ok & size_ok & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= fire;
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/dbk_data_trig_chk.sv
module dbk_data_trig_chk
  import dbk_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DATA_W / 8)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_read_i,
  input logic [1:0]        bus_size_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic [DATA_W-1:0] bus_data_i,
  input logic              hit_o,
  input ctrl_t             ctrl_q,
  input logic [DATA_W-1:0] value_q,
  input logic [DATA_W-1:0] mask_q
);
  logic dir_en, lw_eq;
  assign dir_en = ctrl_q.en & (bus_read_i ? ctrl_q.rd_en : ctrl_q.wr_en);
  assign lw_eq  = ((bus_data_i ^ value_q) & ~mask_q) == '0;

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(bus_valid_i)); // R7
  AST_HIT_DIR_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(dir_en)); // R7
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |=> !hit_o); // R8
  AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(bus_size_i) != SZ_RSVD); // R11
  AST_ALL_ONES_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && dir_en && (&mask_q) && bus_size_i != SZ_RSVD) |=> hit_o); // R10
  AST_LONG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && dir_en && bus_size_i == SZ_LONG && lw_eq) |=> hit_o); // R3

  logic unused_addr;
  assign unused_addr = ^bus_addr_i;
endmodule

bind dbk_data_trig dbk_data_trig_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_read_i  (bus_read_i),
  .bus_size_i  (bus_size_i),
  .bus_addr_i  (bus_addr_i),
  .bus_data_i  (bus_data_i),
  .hit_o       (hit_o),
  .ctrl_q      (ctrl_q),
  .value_q     (value_q),
  .mask_q      (mask_q)
);

// File: tb/sim_dbk_data_trig.sv
`timescale 1ns/1ps
module sim_dbk_data_trig;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        bus_valid_i = 1'b0;
  logic        bus_read_i = 1'b0;
  logic [1:0]  bus_size_i = '0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_data_i = '0;
  logic        hit_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bit    q_exp[$];
  string q_tag[$];

  // shadow registers
  logic [2:0]  m_ctrl = '0;
  logic [31:0] m_val = '0;
  logic [31:0] m_msk = '0;

  always #2 clk_i = ~clk_i;

  dbk_data_trig u0 (.*);

  function automatic bit model(bit v, bit rd, logic [1:0] sz, logic [1:0] a, logic [31:0] d);
    logic [31:0] op, w;
    if (!v || !m_ctrl[0]) return 1'b0;
    if (rd && !m_ctrl[1]) return 1'b0;
    if (!rd && !m_ctrl[2]) return 1'b0;
    case (sz)
      2'b00: begin op = d; w = 32'hFFFF_FFFF; end
      2'b10: begin op = a[1] ? {16'h0, d[15:0]} : {16'h0, d[31:16]}; w = 32'h0000_FFFF; end
      2'b01: begin op = (d >> (8 * (3 - a))) & 32'hFF; w = 32'h0000_00FF; end
      default: return 1'b0;
    endcase
    return ((op ^ m_val) & w & ~m_msk) == 32'h0;
  endfunction

  task automatic cyc(bit we, logic [1:0] ca, logic [31:0] cd,
                     bit v, bit rd, logic [1:0] sz, logic [1:0] a, logic [31:0] d,
                     string tag);
    @(negedge clk_i);
    cfg_we_i = we; cfg_addr_i = ca; cfg_wdata_i = cd;
    bus_valid_i = v; bus_read_i = rd; bus_size_i = sz; bus_addr_i = a; bus_data_i = d;
    q_exp.push_back(model(v, rd, sz, a, d));
    q_tag.push_back(tag);
    if (we) begin
      case (ca)
        2'd0: m_ctrl = cd[2:0];
        2'd1: m_val = cd;
        2'd2: m_msk = cd;
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [1:0] ca, logic [31:0] cd, string tag);
    cyc(1'b1, ca, cd, 1'b0, 1'b0, 2'b00, 2'b00, 32'h0, tag);
  endtask

  task automatic acc(bit rd, logic [1:0] sz, logic [1:0] a, logic [31:0] d, string tag);
    cyc(1'b0, 2'b00, 32'h0, 1'b1, rd, sz, a, d, tag);
  endtask

  // monitor
  bit    m_e;
  string m_t;
  always @(posedge clk_i) begin
    #1;
    if (q_exp.size() > 0) begin
      m_e = q_exp.pop_front();
      m_t = q_tag.pop_front();
      checks++;
      if (hit_o !== m_e) begin
        errors++;
        $display("FAIL %s: hit_o=%b expected %b", m_t, hit_o, m_e);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #10;
    checks++;
    if (hit_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: hit_o=%b in reset expected 0", hit_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: cleared registers, disabled, value 0 data 0 still no hit
    acc(1'b1, 2'b00, 2'b00, 32'h0, "R1 disabled after reset");
    wr(2'd0, 32'h7, "R1 idle");
    // after enabling, zero value/mask registers match zero data
    acc(1'b1, 2'b00, 2'b00, 32'h0, "R1 cleared value matches zero");

    // longword
    wr(2'd1, 32'h1234_5678, "R3 idle");
    acc(1'b1, 2'b00, 2'b00, 32'h1234_5678, "R3 longword a0");
    acc(1'b0, 2'b00, 2'b11, 32'h1234_5678, "R3 longword a3");
    acc(1'b1, 2'b00, 2'b00, 32'h1234_5679, "R2 bit0 compared");
    acc(1'b1, 2'b00, 2'b00, 32'h9234_5678, "R2 bit31 compared");
    wr(2'd2, 32'h8000_0001, "R2 idle");
    acc(1'b1, 2'b00, 2'b10, 32'h9234_5679, "R2 masked bits ignored");
    acc(1'b1, 2'b00, 2'b10, 32'h1234_5670, "R2 unmasked bit still compared");

    // word
    wr(2'd2, 32'h0, "R4 idle");
    wr(2'd1, 32'h0000_ABCD, "R4 idle");
    acc(1'b1, 2'b10, 2'b00, 32'hABCD_0000, "R4 word upper a0");
    acc(1'b1, 2'b10, 2'b01, 32'hABCD_1111, "R4 word a1 ignores A0");
    acc(1'b1, 2'b10, 2'b10, 32'h2222_ABCD, "R4 word lower a2");
    acc(1'b1, 2'b10, 2'b11, 32'h0000_ABCD, "R4 word lower a3");
    acc(1'b1, 2'b10, 2'b10, 32'hABCD_0000, "R4 wrong half");
    acc(1'b1, 2'b10, 2'b00, 32'h0000_ABCD, "R4 wrong half a0");
    wr(2'd1, 32'hFFFF_ABCD, "R6 idle");
    acc(1'b0, 2'b10, 2'b10, 32'h1234_ABCD, "R6 upper value bits ignored for word");
    wr(2'd2, 32'h0000_000F, "R6 idle");
    acc(1'b0, 2'b10, 2'b00, 32'hABC0_5555, "R6 low mask bits apply to word");

    // byte
    wr(2'd2, 32'h0, "R5 idle");
    wr(2'd1, 32'hCCCC_CC5A, "R5 idle");
    for (int a = 0; a < 4; a++)
      acc(1'b1, 2'b01, 2'(a), (32'h5A << (8 * (3 - a))) | (32'h3C3C_3C3C & ~(32'hFF << (8 * (3 - a)))),
          $sformatf("R5 byte lane a%0d", a));
    acc(1'b1, 2'b01, 2'b00, 32'h0000_005A, "R5 byte wrong lane");
    acc(1'b1, 2'b01, 2'b11, 32'h5A00_0000, "R5 byte wrong lane a3");
    acc(1'b1, 2'b01, 2'b01, 32'h005B_0000, "R6 byte value compared");

    // enables
    wr(2'd0, 32'h3, "R7 idle");
    acc(1'b0, 2'b01, 2'b11, 32'h0000_005A, "R7 write disabled");
    acc(1'b1, 2'b01, 2'b11, 32'h0000_005A, "R7 read enabled");
    wr(2'd0, 32'h5, "R7 idle");
    acc(1'b1, 2'b01, 2'b11, 32'h0000_005A, "R7 read disabled");
    acc(1'b0, 2'b01, 2'b11, 32'h0000_005A, "R7 write enabled");
    wr(2'd0, 32'h6, "R7 idle");
    acc(1'b0, 2'b01, 2'b11, 32'h0000_005A, "R7 master off");
    wr(2'd0, 32'h7, "R7 idle");
    cyc(1'b0, 2'b00, 32'h0, 1'b0, 1'b1, 2'b01, 2'b11, 32'h0000_005A, "R7 invalid cycle");

    // pulse shape
    acc(1'b1, 2'b01, 2'b11, 32'h0000_005A, "R8 first of pair");
    acc(1'b1, 2'b01, 2'b11, 32'h0000_005A, "R8 second of pair");
    acc(1'b1, 2'b01, 2'b11, 32'h0000_0000, "R8 mismatch drops");
    cyc(1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 2'b00, 2'b00, 32'h0, "R8 idle low");

    // write timing
    cyc(1'b1, 2'd1, 32'h0000_0077, 1'b1, 1'b1, 2'b01, 2'b11, 32'h0000_005A, "R9 same-cycle uses old");
    acc(1'b1, 2'b01, 2'b11, 32'h0000_0077, "R9 new value next cycle");
    acc(1'b1, 2'b01, 2'b11, 32'h0000_005A, "R9 old value gone");
    wr(2'd3, 32'hFFFF_FFFF, "R9 idle");
    acc(1'b1, 2'b01, 2'b11, 32'h0000_0077, "R9 addr3 write ignored");

    // all-ones mask
    wr(2'd2, 32'hFFFF_FFFF, "R10 idle");
    acc(1'b1, 2'b00, 2'b01, 32'hDEAD_BEEF, "R10 longword any data");
    acc(1'b0, 2'b01, 2'b10, 32'h1357_9BDF, "R10 byte any data");
    acc(1'b0, 2'b10, 2'b11, 32'h0F0F_0F0F, "R10 word any data");

    // reserved size
    acc(1'b1, 2'b11, 2'b00, 32'h0, "R11 reserved size");
    acc(1'b0, 2'b11, 2'b10, 32'hFFFF_FFFF, "R11 reserved size write");

    cyc(1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 2'b00, 2'b00, 32'h0, "R8 tail idle");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule